// File: doc/BRIEF.md
# Learning MAC Output-Port Lookup

This block sits in a switch datapath between the input arbiter and the output queues. Ethernet frames arrive as an AXI4-Stream, one frame per packet, with the ingress port number on `s_tuser` of the first beat. The block reads both MAC addresses from that first beat. It records the sender's address and the port it arrived on in a small register-based content-addressable table. It then looks up the destination address to choose the egress ports.

The decision leaves on `m_tuser` as a one-bit-per-port mask. The frame data itself is forwarded untouched. The first beat is held for two cycles while the table is searched, so the mask is already valid on the first output beat. Each later beat streams through combinationally with the same mask.

Top module: `mac_learn_lookup`

## Requirements
- R1: The destination MAC is `tdata[47:0]` and the source MAC is `tdata[95:48]` of the first beat. The ingress port is the binary value on `s_tuser` during that beat.
- R2: For a destination that is not in the table, `m_tuser` has every port bit set except the ingress port. Bit i of the mask stands for port i.
- R3: A destination of all ones (48'hFFFF_FFFF_FFFF) is always flooded as in R2.
- R4: For a destination that has been learned, `m_tuser` is one-hot on the port stored with it.
- R5: A source address already in the table is updated in place with its new ingress port. The table never holds two entries for one address.
- R6: A new source address takes the lowest free entry. When no entry is free, it overwrites the entry under a replacement pointer that starts at entry 0 after reset and advances by one, wrapping, on each overwrite.
- R7: Every beat leaves with the same `tdata` and `tlast` it arrived with, in order, one output beat per input beat.
- R8: The mask is valid on the first output beat and stays constant for the whole packet. A stalled output beat keeps its data, last flag and mask.
- R9: After reset the table is empty, `m_tvalid` is 0 and `s_tready` is 1. Lookup for a packet uses the table as it was before that packet's own source is learned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_tdata | input | DATA_W | Ingress data |
| s_tvalid | input | 1 | Ingress valid |
| s_tready | output | 1 | Ingress ready |
| s_tlast | input | 1 | Last beat of ingress packet |
| s_tuser | input | PORT_W | Ingress port number, read on the first beat |
| m_tdata | output | DATA_W | Egress data |
| m_tvalid | output | 1 | Egress valid |
| m_tready | input | 1 | Egress ready |
| m_tlast | output | 1 | Last beat of egress packet |
| m_tuser | output | NUM_PORTS | Egress port mask |

## Verification
The stall-stability assertion assumes the upstream source follows AXI4-Stream rules: once it raises valid, it holds the beat until ready is seen. Body beats pass through combinationally, so that property is inherited from the source. The flood assertions assume the ingress port number is below NUM_PORTS. The stimulus keeps every beat asserted until its handshake, uses only port numbers 0 to 3, and throttles `m_tready` at random in the later packets to exercise stalls on both the held first beat and the streamed body.

// File: rtl/mac_learn_lookup.sv
module mac_learn_lookup #(
  parameter int DATA_W    = 128,
  parameter int NUM_PORTS = 4,
  parameter int DEPTH     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DATA_W-1:0]    s_tdata,
  input  logic                 s_tvalid,
  output logic                 s_tready,
  input  logic                 s_tlast,
  input  logic [(NUM_PORTS>1 ? $clog2(NUM_PORTS) : 1)-1:0] s_tuser,
  output logic [DATA_W-1:0]    m_tdata,
  output logic                 m_tvalid,
  input  logic                 m_tready,
  output logic                 m_tlast,
  output logic [NUM_PORTS-1:0] m_tuser
);
  localparam int PORT_W = NUM_PORTS > 1 ? $clog2(NUM_PORTS) : 1;
  localparam int IDX_W  = DEPTH > 1 ? $clog2(DEPTH) : 1;
  localparam logic [NUM_PORTS-1:0] ONE = NUM_PORTS'(1);
  localparam logic [NUM_PORTS-1:0] ALL = {NUM_PORTS{1'b1}};

  typedef enum logic [1:0] {S_HDR, S_LOOK, S_SEND, S_PASS} st_t;
  st_t state;

  logic [DATA_W-1:0]    hdr_data;
  logic                 hdr_last;
  logic [PORT_W-1:0]    src_q;
  logic [NUM_PORTS-1:0] mask_q;
  logic                 miss_q;
  logic [47:0]          mac_tab  [DEPTH];
  logic [PORT_W-1:0]    port_tab [DEPTH];
  logic [DEPTH-1:0]     vld_tab;
  logic [IDX_W-1:0]     rr_ptr;

  wire [47:0] dst_mac = hdr_data[47:0];
  wire [47:0] src_mac = hdr_data[95:48];

  logic [DEPTH-1:0]  dst_hit, src_hit;
  logic [PORT_W-1:0] dst_port;
  logic [IDX_W-1:0]  src_idx, free_idx, wr_idx;
  logic              any_free, flood;

  always_comb begin
    dst_port = '0;
    src_idx  = '0;
    free_idx = '0;
    any_free = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      dst_hit[i] = vld_tab[i] && mac_tab[i] == dst_mac;
      src_hit[i] = vld_tab[i] && mac_tab[i] == src_mac;
      if (dst_hit[i]) dst_port = port_tab[i];
      if (src_hit[i]) src_idx  = IDX_W'(i);
    end
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!vld_tab[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    flood  = !(|dst_hit) || dst_mac == 48'hFFFF_FFFF_FFFF;
    wr_idx = |src_hit ? src_idx : any_free ? free_idx : rr_ptr;
  end

  assign m_tvalid = state == S_SEND || (state == S_PASS && s_tvalid);
  assign m_tdata  = state == S_PASS ? s_tdata : hdr_data;
  assign m_tlast  = state == S_PASS ? s_tlast : hdr_last;
  assign m_tuser  = mask_q;
  assign s_tready = state == S_HDR || (state == S_PASS && m_tready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_HDR;
      hdr_data <= '0;
      hdr_last <= 1'b0;
      src_q    <= '0;
      mask_q   <= '0;
      miss_q   <= 1'b0;
      vld_tab  <= '0;
      rr_ptr   <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        mac_tab[i]  <= '0;
        port_tab[i] <= '0;
      end
    end else begin
      case (state)
        S_HDR:
          if (s_tvalid) begin
            hdr_data <= s_tdata;
            hdr_last <= s_tlast;
            src_q    <= s_tuser;
            state    <= S_LOOK;
          end
        S_LOOK: begin
          mask_q            <= flood ? ALL & ~(ONE << src_q) : ONE << dst_port;
          miss_q            <= flood;
          mac_tab[wr_idx]   <= src_mac;
          port_tab[wr_idx]  <= src_q;
          vld_tab[wr_idx]   <= 1'b1;
          if (!(|src_hit) && !any_free)
            rr_ptr <= rr_ptr == IDX_W'(DEPTH - 1) ? '0 : rr_ptr + 1'b1;
          state <= S_SEND;
        end
        S_SEND:
          if (m_tready) state <= hdr_last ? S_HDR : S_PASS;
        default:
          if (s_tvalid && m_tready && s_tlast) state <= S_HDR;
      endcase
    end
  end

  assert_hold_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tlast) && $stable(m_tuser));
  assert_mask_const_R8: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_PASS |-> $stable(m_tuser));
  assert_flood_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_SEND && miss_q |-> !m_tuser[src_q] && $countones(m_tuser) == NUM_PORTS - 1);
  assert_unicast_R4: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_SEND && !miss_q |-> $countones(m_tuser) == 1);
  assert_unique_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dst_hit) <= 1 && $countones(src_hit) <= 1);
endmodule

// File: tb/mac_learn_lookup_bench.sv
module mac_learn_lookup_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 128;

  logic clk = 0, rst_n = 0;
  logic [DATA_W-1:0] s_tdata = '0, m_tdata;
  logic s_tvalid = 0, s_tlast = 0, s_tready, m_tvalid, m_tlast;
  logic m_tready = 1;
  logic [1:0] s_tuser = '0;
  logic [3:0] m_tuser;
  logic bp = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  logic [DATA_W-1:0] q_data[$];
  logic              q_last[$];
  logic [3:0]        q_mask[$];
  string             q_req[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_learn_lookup #(.DATA_W(DATA_W), .NUM_PORTS(4), .DEPTH(4)) u_mac_learn_lookup (
    .clk(clk), .rst_n(rst_n), .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
    .s_tlast(s_tlast), .s_tuser(s_tuser), .m_tdata(m_tdata), .m_tvalid(m_tvalid),
    .m_tready(m_tready), .m_tlast(m_tlast), .m_tuser(m_tuser));

  always @(negedge clk) m_tready <= bp ? 1'($urandom % 2) : 1'b1;

  task automatic send(input logic [47:0] dst, input logic [47:0] src, input int port,
                      input int nb, input logic [3:0] mask, input string req);
    for (int b = 0; b < nb; b++) begin
      logic [DATA_W-1:0] d;
      bit hs;
      d = (b == 0) ? {32'($urandom), src, dst} : {$urandom, $urandom, $urandom, $urandom};
      q_data.push_back(d); q_last.push_back(b == nb - 1);
      q_mask.push_back(mask); q_req.push_back(req);
      s_tvalid = 1; s_tdata = d; s_tlast = (b == nb - 1); s_tuser = 2'(port);
      hs = 0;
      while (!hs) begin
        #1 hs = s_tready;
        @(negedge clk);
      end
    end
    s_tvalid = 0; s_tlast = 0;
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && m_tvalid && m_tready) begin
      checks++;
      if (q_data.size() == 0) begin
        fails++;
        $display("FAIL R7: unexpected beat actual data=%h expected none", m_tdata);
      end else begin
        logic [DATA_W-1:0] ed; logic el; logic [3:0] em; string r;
        ed = q_data.pop_front(); el = q_last.pop_front();
        em = q_mask.pop_front(); r = q_req.pop_front();
        if (m_tdata !== ed || m_tlast !== el) begin
          fails++;
          $display("FAIL R7: actual data=%h last=%b expected data=%h last=%b", m_tdata, m_tlast, ed, el);
        end
        checks++;
        if (m_tuser !== em) begin
          fails++;
          $display("FAIL %s: actual mask=%b expected mask=%b", r, m_tuser, em);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1 checks++;
    if (m_tvalid !== 1'b0 || s_tready !== 1'b1) begin
      fails++;
      $display("FAIL R9: actual valid=%b ready=%b expected valid=0 ready=1", m_tvalid, s_tready);
    end
    @(negedge clk);
    send(48'h0B, 48'hA1, 0, 1, 4'b1110, "R9 R2 empty table floods");
    send(48'hA1, 48'h0B, 2, 3, 4'b0001, "R4 R1 learned unicast");
    send(48'hFFFF_FFFF_FFFF, 48'h0C, 1, 2, 4'b1101, "R3 all-ones flood");
    send(48'h0B, 48'hA1, 3, 1, 4'b0100, "R4 unicast to port 2");
    send(48'hA1, 48'h0B, 2, 4, 4'b1000, "R5 moved station");
    send(48'h0C, 48'h0D, 0, 2, 4'b0010, "R4 fills last entry");
    send(48'h0D, 48'h0E, 1, 1, 4'b0001, "R6 overwrite on full");
    send(48'hA1, 48'h0E, 1, 2, 4'b1101, "R6 evicted entry floods");
    send(48'h0E, 48'h0B, 2, 3, 4'b0010, "R6 replacement learned");
    bp = 1;
    send(48'h0B, 48'h0F, 3, 4, 4'b0100, "R9 R8 lookup before own learn");
    send(48'h0B, 48'h0C, 0, 3, 4'b1110, "R6 round-robin second eviction");
    send(48'h0E, 48'h0D, 2, 2, 4'b0010, "R8 stalled unicast");
    send(48'h0C, 48'h0E, 3, 1, 4'b0001, "R5 R8 port of moved entry");
    while (q_data.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule